// File: doc/BRIEF.md
# Paged Internal Data Space Decoder

This block sits between an 8-bit controller core and its 256-byte internal data space. Each cycle it takes one access: an 8-bit address, an operation code (byte, bank register or single bit), a flag telling direct from indirect addressing, read and write strobes, write data, the current register-bank number and the current SFR page number. It then routes the access to the on-block RAM or to an external special-function-register bus.

The bottom half of the address space is always RAM. The top half is shared. Indirect byte accesses reach the upper 128 RAM bytes. Direct byte accesses reach a 128-byte SFR window, and the page number carried on the bus chooses which of up to 256 windows is meant. Register operations add the bank number to a 3-bit register index. Bit operations turn a bit number into a byte and a bit position. Low bit numbers land in a 16-byte RAM region, and high bit numbers land on the SFR bus with a one-hot write mask. Read results appear on a registered output one clock after the request.

Top module: `idata_router`

## Requirements
- R1: A byte operation (acc_op = 2'b00) with acc_addr below 0x80 reads or writes RAM byte acc_addr in either addressing mode, and raises no SFR strobe.
- R2: A byte operation with acc_addr at 0x80 or above and acc_indirect = 1 reads or writes RAM byte acc_addr, and raises no SFR strobe.
- R3: A byte operation with acc_addr at 0x80 or above and acc_indirect = 0 raises sfr_rd or sfr_wr in the same cycle. It drives sfr_addr = acc_addr[6:0], sfr_page = page_sel and sfr_wmask = 0xFF, and leaves RAM unchanged. The same offset on different pages reaches different registers.
- R4: A register operation (acc_op = 2'b01) accesses RAM byte bank_sel*8 + acc_addr[2:0]. The upper address bits are ignored and no SFR strobe is raised.
- R5: A bit operation (acc_op = 2'b10) with bit number b below 0x80 targets RAM byte 0x20 + (b >> 3) at bit position b[2:0]. A write sets that bit to wr_data[0] and leaves the other seven bits unchanged. A read returns {7'b0, bit}.
- R6: A bit operation with b at 0x80 or above goes to the SFR bus at offset {b[6:3], 3'b000}. On a write, sfr_wmask is one-hot at b[2:0] and every bit of sfr_wdata equals wr_data[0]. A read returns {7'b0, bit b[2:0] of the register}.
- R7: An SFR read that sfr_ack does not acknowledge in the request cycle returns 0x00. A write to such a register has no visible effect.
- R8: rd_data and rd_valid change one clock after rd_en. rd_valid is high for exactly one cycle per read. A read issued in the cycle after a write to the same location returns the written value.
- R9: After reset, rd_valid = 0, rd_data = 0x00, and every RAM byte reads 0x00.
- R10: Operation code 2'b11 does nothing. It writes nothing, raises no SFR strobe, and its read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_op | input | 2 | Operation: 00 byte, 01 bank register, 10 bit, 11 none |
| acc_indirect | input | 1 | 1 = indirect addressing, 0 = direct |
| acc_addr | input | 8 | Byte address, register index or bit number |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Write data; bit 0 is the value for bit writes |
| bank_sel | input | 2 | Current register bank |
| page_sel | input | 8 | Current SFR page |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | rd_data holds a fresh result |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_page | output | 8 | Page of the SFR access |
| sfr_addr | output | 7 | Offset within the SFR window |
| sfr_wmask | output | 8 | Per-bit write enable for the SFR write |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, valid with sfr_ack |
| sfr_ack | input | 1 | Addressed register exists on this page |

## Verification
The bench writes the same top-half address once through indirect addressing and once through direct addressing. It then reads both back. A decoder that ignores the mode flag would return one value for both. It writes one SFR offset on two pages, so a design that dropped the page would read back the later value on both pages. Bit operations are run on bits 0 and 7 of the region and on a byte that already holds other ones. This catches a wrong shift, an off-by-one byte base, and a store that overwrites the neighbouring bits. Unacknowledged SFR reads and the reserved operation must return zero. A design that forwarded stale bus data, or left the reserved code decoded as a byte access, would fail those checks.

// File: rtl/idr_pkg.sv
package idr_pkg;

   typedef enum logic [1:0] {
      OP_BYTE = 2'b00,
      OP_REG  = 2'b01,
      OP_BIT  = 2'b10,
      OP_NONE = 2'b11
   } idr_op_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'b00,
      TGT_RAM  = 2'b01,
      TGT_SFR  = 2'b10
   } idr_tgt_e;

endpackage

// File: rtl/idr_addr_map.sv
module idr_addr_map
   import idr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned BANK_W   = 2,
   parameter int unsigned REG_W    = 3,
   parameter int unsigned BIT_BASE = 32'h20
) (
   input  logic [1:0]          op,
   input  logic                indirect,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [BANK_W-1:0]   bank,
   input  logic [DATA_W-1:0]   wr_data,
   output idr_tgt_e            tgt,
   output logic [ADDR_W-1:0]   ram_addr,
   output logic [ADDR_W-2:0]   sfr_ofs,
   output logic                is_bit,
   output logic [$clog2(DATA_W)-1:0] pos,
   output logic [DATA_W-1:0]   mask,
   output logic [DATA_W-1:0]   wdata
);
   localparam int unsigned POS_W     = $clog2(DATA_W);
   localparam int unsigned SFR_W     = ADDR_W - 1;
   localparam int unsigned HALF      = 1 << SFR_W;
   localparam int unsigned BIT_BYTES = HALF / DATA_W;
   localparam int unsigned REG_SPAN  = 1 << (BANK_W + REG_W);

   generate
      if ((1 << POS_W) != DATA_W) begin : g_bad_data_w
         $error("DATA_W must be a power of two");
      end
      if (BANK_W + REG_W >= ADDR_W) begin : g_bad_bank
         $error("register banks must fit in the lower half");
      end
      if (BIT_BASE < REG_SPAN || BIT_BASE + BIT_BYTES > HALF) begin : g_bad_bitbase
         $error("bit region must sit above the banks and inside the lower half");
      end
   endgenerate

   idr_op_e op_e;
   assign op_e = idr_op_e'(op);

   always_comb begin
      tgt      = TGT_NONE;
      ram_addr = addr;
      sfr_ofs  = addr[SFR_W-1:0];
      is_bit   = 1'b0;
      pos      = '0;
      mask     = '1;
      wdata    = wr_data;
      case (op_e)
         OP_BYTE: begin
            if (!addr[ADDR_W-1] || indirect) tgt = TGT_RAM;
            else                             tgt = TGT_SFR;
         end
         OP_REG: begin
            tgt      = TGT_RAM;
            ram_addr = ADDR_W'({bank, addr[REG_W-1:0]});
         end
         OP_BIT: begin
            is_bit = 1'b1;
            pos    = addr[POS_W-1:0];
            mask   = DATA_W'(1) << addr[POS_W-1:0];
            wdata  = {DATA_W{wr_data[0]}};
            if (!addr[ADDR_W-1]) begin
               tgt      = TGT_RAM;
               ram_addr = ADDR_W'(BIT_BASE) + ADDR_W'(addr[SFR_W-1:POS_W]);
            end else begin
               tgt     = TGT_SFR;
               sfr_ofs = {addr[SFR_W-1:POS_W], {POS_W{1'b0}}};
            end
         end
         default: tgt = TGT_NONE;
      endcase
   end

endmodule

// File: rtl/idr_ram.sv
module idr_ram #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter bit          RESET_RAM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wmask,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (RESET_RAM) begin : g_rst_mem
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[addr] <= (mem[addr] & ~wmask) | (wdata & wmask);
            end
         end
      end else begin : g_plain_mem
         always_ff @(posedge clk) begin
            if (we) mem[addr] <= (mem[addr] & ~wmask) | (wdata & wmask);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (re) q <= mem[addr];
   end

endmodule

// File: rtl/idr_sfr_port.sv
module idr_sfr_port #(
   parameter int unsigned OFS_W  = 7,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PAGE_W-1:0] page,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [PAGE_W-1:0] bus_page,
   output logic [OFS_W-1:0]  bus_addr,
   output logic [DATA_W-1:0] bus_wmask,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] q
);
   generate
      if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page_w
         $error("PAGE_W must select between 2 and 256 pages");
      end
   endgenerate

   assign bus_rd    = sel && rd_en;
   assign bus_wr    = sel && wr_en;
   assign bus_page  = page;
   assign bus_addr  = ofs;
   assign bus_wmask = mask;
   assign bus_wdata = wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (bus_rd) q <= bus_ack ? bus_rdata : '0;
   end

endmodule

// File: rtl/idata_router.sv
module idata_router
   import idr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned BANK_W    = 2,
   parameter int unsigned REG_W     = 3,
   parameter int unsigned PAGE_W    = 8,
   parameter int unsigned BIT_BASE  = 32'h20,
   parameter bit          RESET_RAM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        acc_op,
   input  logic              acc_indirect,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic [PAGE_W-1:0] page_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              sfr_rd,
   output logic              sfr_wr,
   output logic [PAGE_W-1:0] sfr_page,
   output logic [ADDR_W-2:0] sfr_addr,
   output logic [DATA_W-1:0] sfr_wmask,
   output logic [DATA_W-1:0] sfr_wdata,
   input  logic [DATA_W-1:0] sfr_rdata,
   input  logic              sfr_ack
);
   localparam int unsigned POS_W = $clog2(DATA_W);
   localparam int unsigned OFS_W = ADDR_W - 1;

   idr_tgt_e          tgt;
   logic [ADDR_W-1:0] ram_addr;
   logic [OFS_W-1:0]  sfr_ofs;
   logic              is_bit;
   logic [POS_W-1:0]  pos;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] wdata;
   logic [DATA_W-1:0] ram_q;
   logic [DATA_W-1:0] sfr_q;

   idr_addr_map #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
      .REG_W(REG_W), .BIT_BASE(BIT_BASE)
   ) u_map (
      .op(acc_op), .indirect(acc_indirect), .addr(acc_addr),
      .bank(bank_sel), .wr_data(wr_data), .tgt(tgt),
      .ram_addr(ram_addr), .sfr_ofs(sfr_ofs), .is_bit(is_bit),
      .pos(pos), .mask(mask), .wdata(wdata)
   );

   idr_ram #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_RAM(RESET_RAM)
   ) u_ram (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && tgt == TGT_RAM), .re(rd_en && tgt == TGT_RAM),
      .addr(ram_addr), .wmask(mask), .wdata(wdata), .q(ram_q)
   );

   idr_sfr_port #(
      .OFS_W(OFS_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
   ) u_sfr (
      .clk(clk), .rst_n(rst_n), .sel(tgt == TGT_SFR),
      .rd_en(rd_en), .wr_en(wr_en), .ofs(sfr_ofs), .mask(mask),
      .wdata(wdata), .page(page_sel), .bus_rdata(sfr_rdata),
      .bus_ack(sfr_ack), .bus_rd(sfr_rd), .bus_wr(sfr_wr),
      .bus_page(sfr_page), .bus_addr(sfr_addr), .bus_wmask(sfr_wmask),
      .bus_wdata(sfr_wdata), .q(sfr_q)
   );

   idr_tgt_e          tgt_q;
   logic              bit_q;
   logic [POS_W-1:0]  pos_q;
   logic              valid_q;
   logic [DATA_W-1:0] byte_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q   <= TGT_NONE;
         bit_q   <= 1'b0;
         pos_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= rd_en;
         if (rd_en) begin
            tgt_q <= tgt;
            bit_q <= is_bit;
            pos_q <= pos;
         end
      end
   end

   always_comb begin
      case (tgt_q)
         TGT_RAM: byte_sel = ram_q;
         TGT_SFR: byte_sel = sfr_q;
         default: byte_sel = '0;
      endcase
   end

   assign rd_data  = bit_q ? DATA_W'(byte_sel[pos_q]) : byte_sel;
   assign rd_valid = valid_q;

endmodule

// File: rtl/idr_checker.sv
module idr_checker
   import idr_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        acc_op,
   input logic              acc_indirect,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              rd_en,
   input logic              wr_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid,
   input logic              sfr_rd,
   input logic              sfr_wr,
   input logic [DATA_W-1:0] sfr_wmask,
   input logic              sfr_ack
);
   logic top_half;
   assign top_half = acc_addr[ADDR_W-1];

   p_low_ram_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_op == OP_BYTE && !top_half) |-> (!sfr_rd && !sfr_wr));

   p_indirect_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_op == OP_BYTE && acc_indirect) |-> (!sfr_rd && !sfr_wr));

   p_direct_rd_sfr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && acc_op == OP_BYTE && !acc_indirect && top_half) |-> sfr_rd);

   p_direct_wr_sfr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && acc_op == OP_BYTE && !acc_indirect && top_half)
         |-> (sfr_wr && sfr_wmask == '1));

   p_reg_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_op == OP_REG) |-> (!sfr_rd && !sfr_wr));

   p_bit_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_wr && acc_op == OP_BIT) |-> ($countones(sfr_wmask) == 1));

   p_unack_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_rd && !sfr_ack) |=> (rd_data == '0));

   p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   p_valid_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   p_none_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_op == OP_NONE) |-> (!sfr_rd && !sfr_wr));

   p_none_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && acc_op == OP_NONE) |=> (rd_data == '0));

endmodule

bind idata_router idr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_op(acc_op), .acc_indirect(acc_indirect),
   .acc_addr(acc_addr), .rd_en(rd_en), .wr_en(wr_en), .rd_data(rd_data),
   .rd_valid(rd_valid), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
   .sfr_wmask(sfr_wmask), .sfr_ack(sfr_ack)
);

// File: tb/tb_idata_router.sv
`timescale 1ns/1ps
module tb_idata_router;

   typedef struct packed {
      logic [1:0] op;
      logic       ind;
      logic       rd;
      logic       wr;
      logic [7:0] addr;
      logic [7:0] wd;
      logic [1:0] bank;
      logic [7:0] page;
      logic       chk;
      logic [7:0] exp;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 35;
   // op: 0 byte, 1 register, 2 bit, 3 none
   localparam vec_t VECS [NV] = '{
      '{2'd0,1'b1,1'b1,1'b0,8'hFF,8'h00,2'd0,8'd0,1'b1,8'h00,4'd9},  // R9 fresh RAM
      '{2'd0,1'b0,1'b0,1'b1,8'h05,8'h11,2'd0,8'd0,1'b0,8'h00,4'd1},  // R1
      '{2'd0,1'b1,1'b1,1'b0,8'h05,8'h00,2'd0,8'd0,1'b1,8'h11,4'd1},  // R1
      '{2'd0,1'b1,1'b0,1'b1,8'h90,8'h5A,2'd0,8'd0,1'b0,8'h00,4'd2},  // R2
      '{2'd0,1'b0,1'b0,1'b1,8'h90,8'hC3,2'd0,8'd0,1'b0,8'h00,4'd3},  // R3
      '{2'd0,1'b1,1'b1,1'b0,8'h90,8'h00,2'd0,8'd0,1'b1,8'h5A,4'd2},  // R2 RAM kept
      '{2'd0,1'b0,1'b1,1'b0,8'h90,8'h00,2'd0,8'd0,1'b1,8'hC3,4'd3},  // R3
      '{2'd0,1'b0,1'b0,1'b1,8'h90,8'h3C,2'd0,8'd3,1'b0,8'h00,4'd3},  // R3 page 3
      '{2'd0,1'b0,1'b1,1'b0,8'h90,8'h00,2'd0,8'd0,1'b1,8'hC3,4'd3},  // R3
      '{2'd0,1'b0,1'b1,1'b0,8'h90,8'h00,2'd0,8'd3,1'b1,8'h3C,4'd3},  // R3
      '{2'd1,1'b0,1'b0,1'b1,8'h05,8'h77,2'd2,8'd0,1'b0,8'h00,4'd4},  // R4
      '{2'd0,1'b0,1'b1,1'b0,8'h15,8'h00,2'd0,8'd0,1'b1,8'h77,4'd4},  // R4
      '{2'd1,1'b0,1'b1,1'b0,8'h05,8'h00,2'd0,8'd0,1'b1,8'h11,4'd4},  // R4
      '{2'd1,1'b0,1'b1,1'b0,8'h0D,8'h00,2'd3,8'd0,1'b1,8'h00,4'd4},  // R4
      '{2'd0,1'b0,1'b0,1'b1,8'h22,8'hF0,2'd0,8'd0,1'b0,8'h00,4'd5},  // R5
      '{2'd2,1'b0,1'b0,1'b1,8'h10,8'h01,2'd0,8'd0,1'b0,8'h00,4'd5},  // R5
      '{2'd0,1'b0,1'b1,1'b0,8'h22,8'h00,2'd0,8'd0,1'b1,8'hF1,4'd5},  // R5
      '{2'd2,1'b0,1'b0,1'b1,8'h7F,8'h01,2'd0,8'd0,1'b0,8'h00,4'd5},  // R5
      '{2'd0,1'b0,1'b1,1'b0,8'h2F,8'h00,2'd0,8'd0,1'b1,8'h80,4'd5},  // R5
      '{2'd2,1'b0,1'b1,1'b0,8'h7F,8'h00,2'd0,8'd0,1'b1,8'h01,4'd5},  // R5
      '{2'd2,1'b0,1'b1,1'b0,8'h7E,8'h00,2'd0,8'd0,1'b1,8'h00,4'd5},  // R5
      '{2'd2,1'b0,1'b0,1'b1,8'h10,8'hFE,2'd0,8'd0,1'b0,8'h00,4'd5},  // R5
      '{2'd0,1'b0,1'b1,1'b0,8'h22,8'h00,2'd0,8'd0,1'b1,8'hF0,4'd5},  // R5
      '{2'd2,1'b0,1'b0,1'b1,8'hAB,8'h01,2'd0,8'd0,1'b0,8'h00,4'd6},  // R6
      '{2'd0,1'b0,1'b1,1'b0,8'hA8,8'h00,2'd0,8'd0,1'b1,8'h08,4'd6},  // R6
      '{2'd2,1'b0,1'b1,1'b0,8'hAB,8'h00,2'd0,8'd0,1'b1,8'h01,4'd6},  // R6
      '{2'd2,1'b0,1'b1,1'b0,8'hAC,8'h00,2'd0,8'd0,1'b1,8'h00,4'd6},  // R6
      '{2'd0,1'b0,1'b0,1'b1,8'hB0,8'hFF,2'd0,8'd0,1'b0,8'h00,4'd7},  // R7
      '{2'd0,1'b0,1'b1,1'b0,8'hB0,8'h00,2'd0,8'd0,1'b1,8'h00,4'd7},  // R7
      '{2'd0,1'b0,1'b1,1'b0,8'h90,8'h00,2'd0,8'd5,1'b1,8'h00,4'd7},  // R7 page 5
      '{2'd3,1'b0,1'b0,1'b1,8'h05,8'hEE,2'd0,8'd0,1'b0,8'h00,4'd10}, // R10
      '{2'd0,1'b0,1'b1,1'b0,8'h05,8'h00,2'd0,8'd0,1'b1,8'h11,4'd10}, // R10
      '{2'd3,1'b0,1'b1,1'b0,8'h05,8'h00,2'd0,8'd0,1'b1,8'h00,4'd10}, // R10
      '{2'd0,1'b0,1'b0,1'b1,8'h40,8'h9D,2'd0,8'd0,1'b0,8'h00,4'd8},  // R8
      '{2'd0,1'b1,1'b1,1'b0,8'h40,8'h00,2'd0,8'd0,1'b1,8'h9D,4'd8}   // R8
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] acc_op = 2'd0;
   logic       acc_indirect = 1'b0;
   logic [7:0] acc_addr = 8'h00;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] bank_sel = 2'd0;
   logic [7:0] page_sel = 8'd0;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic       sfr_rd, sfr_wr;
   logic [7:0] sfr_page;
   logic [6:0] sfr_addr;
   logic [7:0] sfr_wmask, sfr_wdata;
   logic [7:0] sfr_rdata;
   logic       sfr_ack;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   idata_router dut (
      .clk(clk), .rst_n(rst_n), .acc_op(acc_op), .acc_indirect(acc_indirect),
      .acc_addr(acc_addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
      .bank_sel(bank_sel), .page_sel(page_sel), .rd_data(rd_data),
      .rd_valid(rd_valid), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
      .sfr_page(sfr_page), .sfr_addr(sfr_addr), .sfr_wmask(sfr_wmask),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_ack(sfr_ack)
   );

   // SFR stub: page 0 offsets 0x10 and 0x28, page 3 offset 0x10
   logic [7:0] s0_10, s0_28, s3_10;
   logic       h0_10, h0_28, h3_10;
   assign h0_10 = (sfr_page == 8'd0) && (sfr_addr == 7'h10);
   assign h0_28 = (sfr_page == 8'd0) && (sfr_addr == 7'h28);
   assign h3_10 = (sfr_page == 8'd3) && (sfr_addr == 7'h10);
   assign sfr_ack   = (sfr_rd || sfr_wr) && (h0_10 || h0_28 || h3_10);
   assign sfr_rdata = h0_10 ? s0_10 : h0_28 ? s0_28 : h3_10 ? s3_10 : 8'hA5;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s0_10 <= 8'h00; s0_28 <= 8'h00; s3_10 <= 8'h00;
      end else if (sfr_wr) begin
         if (h0_10) s0_10 <= (s0_10 & ~sfr_wmask) | (sfr_wdata & sfr_wmask);
         if (h0_28) s0_28 <= (s0_28 & ~sfr_wmask) | (sfr_wdata & sfr_wmask);
         if (h3_10) s3_10 <= (s3_10 & ~sfr_wmask) | (sfr_wdata & sfr_wmask);
      end
   end

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] op, input logic ind, input logic rd,
                        input logic wr, input logic [7:0] a, input logic [7:0] wd,
                        input logic [1:0] bk, input logic [7:0] pg);
      acc_op = op; acc_indirect = ind; rd_en = rd; wr_en = wr;
      acc_addr = a; wr_data = wd; bank_sel = bk; page_sel = pg;
   endtask

   task automatic idle();
      drive(2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 2'd0, 8'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 rd_valid", {7'b0, rd_valid}, 8'h00);
      check("R9 rd_data", rd_data, 8'h00);

      // table walk
      begin
         bit   pend = 1'b0;
         vec_t prev = '0;
         for (int i = 0; i < NV; i++) begin
            if (pend) check($sformatf("R%0d vector %0d", prev.req, i - 1), rd_data, prev.exp);
            drive(VECS[i].op, VECS[i].ind, VECS[i].rd, VECS[i].wr,
                  VECS[i].addr, VECS[i].wd, VECS[i].bank, VECS[i].page);
            pend = VECS[i].chk;
            prev = VECS[i];
            @(negedge clk);
         end
         if (pend) check($sformatf("R%0d vector %0d", prev.req, NV - 1), rd_data, prev.exp);
         idle();
      end

      // R3 strobe fields
      @(negedge clk);
      drive(2'd0, 1'b0, 1'b0, 1'b1, 8'h90, 8'h12, 2'd0, 8'd3);
      #1;
      check("R3 sfr_wr", {7'b0, sfr_wr}, 8'h01);
      check("R3 sfr_addr", {1'b0, sfr_addr}, 8'h10);
      check("R3 sfr_page", sfr_page, 8'h03);
      check("R3 sfr_wmask", sfr_wmask, 8'hFF);
      // R2 indirect upper byte stays off the bus
      @(negedge clk);
      drive(2'd0, 1'b1, 1'b1, 1'b1, 8'hA0, 8'h44, 2'd0, 8'd0);
      #1;
      check("R2 no sfr strobe", {6'b0, sfr_rd, sfr_wr}, 8'h00);
      // R6 bit write fields
      @(negedge clk);
      drive(2'd2, 1'b0, 1'b0, 1'b1, 8'hAB, 8'h01, 2'd0, 8'd0);
      #1;
      check("R6 sfr_wmask", sfr_wmask, 8'h08);
      check("R6 sfr_addr", {1'b0, sfr_addr}, 8'h28);
      check("R6 sfr_wdata", sfr_wdata, 8'hFF);

      // R8 valid pulse
      @(negedge clk);
      drive(2'd0, 1'b0, 1'b1, 1'b0, 8'h05, 8'h00, 2'd0, 8'd0);
      @(negedge clk);
      idle();
      check("R8 rd_valid high", {7'b0, rd_valid}, 8'h01);
      check("R8 rd_data", rd_data, 8'h11);
      @(negedge clk);
      check("R8 rd_valid low", {7'b0, rd_valid}, 8'h00);

      // R9 reset mid-run clears RAM
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check("R9 rd_data after reset", rd_data, 8'h00);
      check("R9 rd_valid after reset", {7'b0, rd_valid}, 8'h00);
      @(negedge clk);
      drive(2'd0, 1'b1, 1'b1, 1'b0, 8'h05, 8'h00, 2'd0, 8'd0);
      @(negedge clk);
      idle();
      check("R9 RAM cleared", rd_data, 8'h00);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule